// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Master with Slave-Select Control

This block is a serial peripheral bus master that trades one 8-bit character in each direction per transfer. It drives the serial clock, the outgoing data line and a set of active-low slave-select lines, and it samples the incoming data line. The serial clock is derived from the system clock by a parameterized divide ratio. Clock idle level, clock phase and bit order are chosen by configuration inputs.

Software-side logic writes characters into a small transmit FIFO and reads results from a small receive FIFO. Characters follow one another with no pause for as long as the transmit FIFO has data and the receive FIFO has room. When the receive FIFO is full, the serial clock is held before the next character begins, so no received data is lost. The slave-select lines work in one of two modes. In manual mode they mirror a select mask for as long as the master is enabled. In automatic mode they are asserted only while a character is being shifted.

A mode-fault detector watches an external active-low select input. If another master pulls that input low while this master is enabled, the detector disables the master, releases its output drivers and sets a sticky flag. That flag can raise an interrupt through its own enable input.

Top module: `spim_master`

## Requirements
- R1: Each character exchanges 8 bits both ways at once: the byte pushed into the transmit FIFO appears on `mosi_o` and the 8 bits sampled from `miso_i` are pushed into the receive FIFO, in push order.
- R2: `sclk_o` rests at the level of `cpol` between characters. With `cpha`=0, data is sampled on the first (leading) clock edge and the first bit is on `mosi_o` before it. With `cpha`=1, data changes on leading edges and is sampled on trailing edges.
- R3: With `lsb_first`=0 bit 7 is shifted first; with `lsb_first`=1 bit 0 is shifted first, in both directions.
- R4: While a character is shifted, every half period of `sclk_o` lasts DIV/2 system clocks (DIV even, at least 2).
- R5: Manual mode (`auto_ss`=0): `ss_n_o` equals the inverse of `ss_sel` while the master is enabled and is all ones while it is disabled.
- R6: Automatic mode (`auto_ss`=1): a selected line is low only while a character is being shifted and goes high between characters; unselected lines stay high.
- R7: In manual mode, consecutive characters run with no gap in the serial clock and no change on the selected line, while the transmit FIFO is non-empty and the receive FIFO has room.
- R8: No character starts while the receive FIFO is full; shifting resumes after a pop, and no received byte is lost.
- R9: When the master is enabled and `ss_in_n` is low, within 3 system clocks `modf` becomes 1, `master_en` and `drv_en_o` become 0, any transfer in progress is abandoned, and `ss_n_o` goes all ones. `modf` stays set until `modf_clr` is pulsed.
- R10: `irq` is high exactly when `modf` and `modf_ie` are both high.
- R11: `xfer_done` pulses for one cycle when a character completes and the transmit FIFO is empty; `tx_empty` is high whenever the transmit FIFO holds nothing.
- R12: After reset the master is disabled, both FIFOs are empty, `modf` and `irq` are 0, `ss_n_o` is all ones and `sclk_o` is at the `cpol` level.
- R13: A push into the full transmit FIFO is ignored: the stored characters and their order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Pulse: enable the master |
| en_clr | input | 1 | Pulse: disable the master |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1: shift bit 0 first |
| auto_ss | input | 1 | 1: automatic per-character slave select |
| ss_sel | input | NSS | Slave-select mask, one bit per line |
| modf_ie | input | 1 | Mode-fault interrupt enable |
| modf_clr | input | 1 | Pulse: clear the mode-fault flag |
| tx_data | input | 8 | Character to transmit |
| tx_push | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_data | output | 8 | Oldest received character (show-ahead) |
| rx_pop | input | 1 | Remove the oldest received character |
| rx_empty | output | 1 | Receive FIFO empty |
| xfer_done | output | 1 | One-cycle pulse: last queued character finished |
| modf | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Mode-fault interrupt |
| master_en | output | 1 | Master enable state |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NSS | Active-low slave-select lines |
| ss_in_n | input | 1 | External active-low select, watched for mode fault |
| drv_en_o | output | 1 | Output driver enable |

## Verification
The bench puts a behavioural slave on the serial lines and covers all four polarity/phase pairs in both bit orders. A wrong sampling edge or bit order shows up as shifted or mirrored bytes on one side. It runs a back-to-back burst and counts clock intervals and select edges: a design that paused between characters would show a long interval or a select pulse, while an automatic mode that held select low would show too few select pulses. It fills the receive FIFO to check that shifting stops instead of overwriting a byte. It pushes into a full transmit FIFO, where a wrong design would drop or reorder characters. It raises a mode fault in the middle of a character: a design that ignored it would go on clocking and store a partial byte.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } spim_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic auto_ss;
    } spim_cfg_t;

    // bit that leaves the shifter next
    function automatic logic out_bit(input char_t v, input logic lsb);
        return lsb ? v[0] : v[CHAR_W-1];
    endfunction

    // shifter contents after one bit has left
    function automatic char_t shift_out(input char_t v, input logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    // receive shifter after one bit has arrived
    function automatic char_t shift_in(input char_t v, input logic b, input logic lsb);
        return lsb ? {b, v[CHAR_W-1:1]} : {v[CHAR_W-2:0], b};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;
    logic         full, empty, do_push, do_pop;

    assign count   = CW'(wr_ptr - rd_ptr);
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    // R13: a push against a full store leaves the occupancy unchanged
    assert_full_push_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  spim_cfg_t                       cfg,
    input  logic                            tx_valid,
    input  char_t                           tx_data,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0] rx_free,
    input  logic                            miso,
    output logic                            tx_pop,
    output logic                            rx_push,
    output char_t                           rx_data,
    output logic                            sclk,
    output logic                            mosi,
    output logic                            active
);
    localparam int HALF = DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int EW   = $clog2(2 * CHAR_W);
    localparam int CW   = $clog2(FIFO_DEPTH+1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * CHAR_W - 1);

    spim_state_e   state;
    logic [HW-1:0] hcnt;
    logic [EW-1:0] edge_q;
    char_t         txsh, rxsh, rx_nxt;
    logic          sclk_q, mosi_q;
    logic          tick, samp_ev, drv_ev, last, go_start, go_cont;

    assign tick     = (hcnt == HW'(HALF - 1));
    assign samp_ev  = (state == ST_SHIFT) && tick && (edge_q[0] == cfg.cpha);
    assign drv_ev   = (state == ST_SHIFT) && tick && (edge_q[0] != cfg.cpha);
    assign last     = en && (state == ST_SHIFT) && tick && (edge_q == LAST_EDGE);
    assign rx_nxt   = samp_ev ? shift_in(rxsh, miso, cfg.lsb_first) : rxsh;
    assign go_start = en && (state == ST_IDLE) && tx_valid && (rx_free != '0);
    assign go_cont  = last && tx_valid && (rx_free >= CW'(2)) && !cfg.auto_ss;

    assign tx_pop  = go_start || go_cont;
    assign rx_push = last;
    assign rx_data = rx_nxt;
    assign sclk    = (state == ST_SHIFT) ? sclk_q : cfg.cpol;
    assign mosi    = mosi_q;
    assign active  = (state == ST_LEAD) || (state == ST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hcnt   <= '0;
            edge_q <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            txsh   <= '0;
            rxsh   <= '0;
        end else if (!en) begin
            state  <= ST_IDLE;
            hcnt   <= '0;
            edge_q <= '0;
            sclk_q <= cfg.cpol;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    hcnt   <= '0;
                    edge_q <= '0;
                    sclk_q <= cfg.cpol;
                    if (go_start) begin
                        state <= ST_LEAD;
                        txsh  <= tx_data;
                        if (!cfg.cpha) begin
                            mosi_q <= out_bit(tx_data, cfg.lsb_first);
                            txsh   <= shift_out(tx_data, cfg.lsb_first);
                        end
                    end
                end
                ST_LEAD: begin
                    sclk_q <= cfg.cpol;
                    if (tick) begin
                        hcnt  <= '0;
                        state <= ST_SHIFT;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        hcnt   <= '0;
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + 1'b1;
                        rxsh   <= rx_nxt;
                        if (drv_ev) begin
                            mosi_q <= out_bit(txsh, cfg.lsb_first);
                            txsh   <= shift_out(txsh, cfg.lsb_first);
                        end
                        if (last) begin
                            if (go_cont) begin
                                txsh <= tx_data;
                                if (!cfg.cpha) begin
                                    mosi_q <= out_bit(tx_data, cfg.lsb_first);
                                    txsh   <= shift_out(tx_data, cfg.lsb_first);
                                end
                            end else begin
                                state <= cfg.auto_ss ? ST_GAP : ST_IDLE;
                            end
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        hcnt  <= '0;
                        state <= ST_IDLE;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R4: the serial clock holds between divider ticks
    assert_halfperiod_R4: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_SHIFT && !tick) |=> $stable(sclk_q));

    // R1: a character is only taken from a non-empty transmit store
    assert_pop_valid_R1: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> tx_valid);

endmodule

// File: rtl/spim_ssel.sv
module spim_ssel #(
    parameter int NSS = 2
) (
    input  logic           en,
    input  logic           auto_mode,
    input  logic           active,
    input  logic [NSS-1:0] sel,
    output logic [NSS-1:0] ss_n
);
    logic drive;

    assign drive = en && (!auto_mode || active);

    for (genvar g = 0; g < NSS; g++) begin : g_line
        assign ss_n[g] = !(sel[g] && drive);
    end

endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int NSS        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              auto_ss,
    input  logic [NSS-1:0]    ss_sel,
    input  logic              modf_ie,
    input  logic              modf_clr,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_push,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [CHAR_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic              rx_empty,
    output logic              xfer_done,
    output logic              modf,
    output logic              irq,
    output logic              master_en,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NSS-1:0]    ss_n_o,
    input  logic              ss_in_n,
    output logic              drv_en_o
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    spim_cfg_t cfg;
    logic [CW-1:0] tx_cnt, rx_cnt, rx_free;
    char_t   tx_head, rx_word;
    logic    tx_pop, rx_push, rx_full, eng_active;
    logic    ss_s1, ss_s2, fault, en_q, modf_q;

    assign cfg = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first, auto_ss: auto_ss};

    spim_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt)
    );

    spim_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data), .count(rx_cnt)
    );

    assign tx_full  = (tx_cnt == CW'(FIFO_DEPTH));
    assign tx_empty = (tx_cnt == '0);
    assign rx_full  = (rx_cnt == CW'(FIFO_DEPTH));
    assign rx_empty = (rx_cnt == '0);
    assign rx_free  = CW'(FIFO_DEPTH) - rx_cnt;

    spim_engine #(.DIV(DIV), .FIFO_DEPTH(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst(rst), .en(en_q), .cfg(cfg),
        .tx_valid(!tx_empty), .tx_data(tx_head), .rx_free(rx_free),
        .miso(miso_i), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .sclk(sclk_o), .mosi(mosi_o), .active(eng_active)
    );

    spim_ssel #(.NSS(NSS)) u_ss (
        .en(en_q), .auto_mode(auto_ss), .active(eng_active),
        .sel(ss_sel), .ss_n(ss_n_o)
    );

    // external select input: two-stage synchronizer
    always_ff @(posedge clk) begin
        if (rst) begin
            ss_s1 <= 1'b1;
            ss_s2 <= 1'b1;
        end else begin
            ss_s1 <= ss_in_n;
            ss_s2 <= ss_s1;
        end
    end

    assign fault = en_q && !ss_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            modf_q <= 1'b0;
        end else begin
            if (fault || en_clr) en_q <= 1'b0;
            else if (en_set)     en_q <= 1'b1;
            if (fault)           modf_q <= 1'b1;
            else if (modf_clr)   modf_q <= 1'b0;
        end
    end

    assign master_en = en_q;
    assign drv_en_o  = en_q;
    assign modf      = modf_q;
    assign irq       = modf_q && modf_ie;
    assign xfer_done = rx_push && tx_empty;

    // R8: the engine never delivers into a full receive store
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    // R9: a detected fault disables the master and latches the flag
    assert_modf_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> (modf_q && !en_q));

    // R6: in automatic mode, a toggling clock implies the selected lines are driven
    assert_auto_ss_R6: assert property (@(posedge clk) disable iff (rst)
        (auto_ss && en_q && sclk_o != cpol) |-> (ss_n_o == ~ss_sel));

endmodule

// File: tb/sim_spim_master.sv
module sim_spim_master;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int DEPTH = 4;
    localparam int NSS   = 2;
    localparam int NVEC  = 8;

    // {cpol, cpha, lsb_first, master byte, slave base byte}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 1'b0, 8'h81, 8'h7E},
        {1'b1, 1'b0, 1'b0, 8'hF0, 8'h0F},
        {1'b1, 1'b1, 1'b0, 8'h5A, 8'hC3},
        {1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
        {1'b0, 1'b1, 1'b1, 8'hC8, 8'h12},
        {1'b1, 1'b0, 1'b1, 8'h37, 8'hE9},
        {1'b1, 1'b1, 1'b1, 8'h6D, 8'hB4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_set = 0, en_clr = 0, cpol = 0, cpha = 0, lsb_first = 0, auto_ss = 0;
    logic [NSS-1:0] ss_sel = '0;
    logic modf_ie = 0, modf_clr = 0, tx_push = 0, rx_pop = 0, ss_in_n = 1;
    logic [7:0] tx_data = '0;
    logic miso;
    logic tx_full, tx_empty, rx_empty, xfer_done, modf, irq, master_en;
    logic sclk_o, mosi_o, drv_en_o;
    logic [7:0] rx_data;
    logic [NSS-1:0] ss_n_o;

    always #10 clk = ~clk;

    spim_master #(.DIV(DIV), .FIFO_DEPTH(DEPTH), .NSS(NSS)) u0 (
        .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .auto_ss(auto_ss),
        .ss_sel(ss_sel), .modf_ie(modf_ie), .modf_clr(modf_clr),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_pop(rx_pop), .rx_empty(rx_empty),
        .xfer_done(xfer_done), .modf(modf), .irq(irq), .master_en(master_en),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso),
        .ss_n_o(ss_n_o), .ss_in_n(ss_in_n), .drv_en_o(drv_en_o)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural slave and monitors
    bit mon_on = 0;
    int bc = 0, nrx = 0, cyc = 0, last_edge = -1, hp_bad = 0, ss_rise = 0, done_cnt = 0;
    logic [7:0] sl_sh = '0;
    logic [7:0] slv_base = '0;
    logic [7:0] sl_got [16];
    logic [7:0] cur_w;

    function automatic logic [7:0] slave_word(input logic [7:0] base, input int n);
        return base + 8'(n * 59);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    always @* begin
        cur_w = slave_word(slv_base, nrx);
        miso  = cur_w[7 - (bc % 8)];
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_on && xfer_done) done_cnt = done_cnt + 1;
    end

    always @(sclk_o) begin
        if (mon_on) begin
            if (last_edge >= 0 && (cyc - last_edge) != HALF) hp_bad = hp_bad + 1;
            last_edge = cyc;
            if ((sclk_o != cpol) != cpha) begin
                sl_sh = {sl_sh[6:0], mosi_o};
                bc = bc + 1;
                if (bc == 8) begin
                    sl_got[nrx % 16] = sl_sh;
                    nrx = nrx + 1;
                    bc = 0;
                end
            end
        end
    end

    always @(posedge ss_n_o[0]) if (mon_on) ss_rise = ss_rise + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setup(input logic p, input logic h, input logic l, input logic a,
                         input logic [7:0] base);
        @(negedge clk);
        mon_on = 0;
        cpol = p; cpha = h; lsb_first = l; auto_ss = a;
        @(negedge clk);
        bc = 0; nrx = 0; sl_sh = '0; slv_base = base;
        last_edge = -1; hp_bad = 0; ss_rise = 0; done_cnt = 0;
        mon_on = 1;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_push = 1;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        v = rx_data; rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic wait_slave(input int n);
        int t = 0;
        while (nrx < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (2 * DIV + 4) @(negedge clk);
    endtask

    task automatic pulse_en(input bit on);
        @(negedge clk);
        if (on) en_set = 1; else en_clr = 1;
        @(negedge clk);
        en_set = 0; en_clr = 0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        logic [7:0] v, exp_rx, exp_tx;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        chk(ss_n_o == 2'b11, "R12 ss_n", ss_n_o, 2'b11);
        chk(sclk_o == 1'b0, "R12 sclk", sclk_o, 0);
        chk(tx_empty && rx_empty && !tx_full, "R12 fifos", {tx_empty, rx_empty, tx_full}, 3'b110);
        chk(!modf && !irq && !master_en && !drv_en_o, "R12 flags",
            {modf, irq, master_en, drv_en_o}, 0);

        // R5: manual select mirrors mask when enabled
        ss_sel = 2'b10;
        pulse_en(1);
        chk(ss_n_o == 2'b01, "R5 manual enabled", ss_n_o, 2'b01);
        auto_ss = 1;
        @(negedge clk);
        chk(ss_n_o == 2'b11, "R6 auto idle", ss_n_o, 2'b11);
        auto_ss = 0;
        ss_sel = 2'b01;

        // table of single characters across modes
        for (int k = 0; k < NVEC; k++) begin
            setup(VEC[k][18], VEC[k][17], VEC[k][16], 1'b0, VEC[k][7:0]);
            push(VEC[k][15:8]);
            wait_slave(1);
            exp_rx = VEC[k][16] ? rev8(VEC[k][7:0]) : VEC[k][7:0];
            exp_tx = VEC[k][16] ? rev8(VEC[k][15:8]) : VEC[k][15:8];
            chk(!rx_empty, "R1 rx present", rx_empty, 0);
            chk(sl_got[0] == exp_tx, "R1/R3 slave got", sl_got[0], exp_tx);
            pop(v);
            chk(v == exp_rx, "R2/R3 master got", v, exp_rx);
            chk(sclk_o == VEC[k][18], "R2 idle level", sclk_o, VEC[k][18]);
            chk(hp_bad == 0, "R4 half period", hp_bad, 0);
            chk(done_cnt == 1 && tx_empty, "R11 done pulse", done_cnt, 1);
        end

        // R7: back-to-back manual burst
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
        for (int i = 0; i < 4; i++) push(8'h20 + 8'(i * 17));
        wait_slave(4);
        chk(hp_bad == 0, "R7 no clock gap", hp_bad, 0);
        chk(ss_rise == 0, "R7 select held", ss_rise, 0);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);
        for (int i = 0; i < 4; i++) begin
            chk(sl_got[i] == 8'h20 + 8'(i * 17), "R1 burst slave", sl_got[i], 8'h20 + 8'(i * 17));
            pop(v);
            chk(v == slave_word(8'hA5, i), "R1 burst master", v, slave_word(8'hA5, i));
        end

        // R6: automatic select per character
        setup(1'b1, 1'b1, 1'b0, 1'b1, 8'h3C);
        for (int i = 0; i < 3; i++) push(8'h90 + 8'(i));
        wait_slave(3);
        chk(ss_rise == 3, "R6 select pulses", ss_rise, 3);
        chk(ss_n_o == 2'b11, "R6 idle high", ss_n_o, 2'b11);
        for (int i = 0; i < 3; i++) begin
            pop(v);
            chk(v == slave_word(8'h3C, i), "R6 auto data", v, slave_word(8'h3C, i));
        end
        auto_ss = 0;

        // R8: receive-full stall
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h10);
        for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
        wait_slave(4);
        push(8'h44); push(8'h45);
        repeat (300) @(negedge clk);
        chk(nrx == 4, "R8 stalled", nrx, 4);
        chk(!tx_empty, "R8 tx kept", tx_empty, 0);
        pop(v);
        chk(v == rev8(slave_word(8'h10, 0)), "R8 first", v, rev8(slave_word(8'h10, 0)));
        wait_slave(5);
        repeat (100) @(negedge clk);
        chk(nrx == 5, "R8 one resumed", nrx, 5);
        for (int i = 1; i < 5; i++) begin
            pop(v);
            chk(v == rev8(slave_word(8'h10, i)), "R8 no loss", v, rev8(slave_word(8'h10, i)));
        end
        wait_slave(6);
        pop(v);
        chk(v == rev8(slave_word(8'h10, 5)), "R8 last", v, rev8(slave_word(8'h10, 5)));

        // R13: push into full transmit FIFO
        pulse_en(0);
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        for (int i = 1; i <= 5; i++) push(8'(i * 8'h11));
        chk(tx_full, "R13 full", tx_full, 1);
        chk(ss_n_o == 2'b11, "R5 disabled", ss_n_o, 2'b11);
        pulse_en(1);
        wait_slave(4);
        repeat (200) @(negedge clk);
        chk(nrx == 4 && tx_empty, "R13 count", nrx, 4);
        chk(sl_got[3] == 8'h44, "R13 order", sl_got[3], 8'h44);
        for (int i = 0; i < 4; i++) pop(v);

        // R9/R10: mode fault in the middle of a character
        setup(1'b1, 1'b0, 1'b0, 1'b0, 8'h55);
        push(8'hC3);
        repeat (12) @(negedge clk);
        ss_in_n = 0;
        repeat (3) @(negedge clk);
        chk(modf && !master_en && !drv_en_o, "R9 fault", {modf, master_en, drv_en_o}, 3'b100);
        chk(ss_n_o == 2'b11 && sclk_o == 1'b1, "R9 released", {ss_n_o, sclk_o}, 3'b111);
        chk(!irq, "R10 masked", irq, 0);
        modf_ie = 1;
        @(negedge clk);
        chk(irq, "R10 enabled", irq, 1);
        ss_in_n = 1;
        repeat (50) @(negedge clk);
        chk(rx_empty && nrx == 0, "R9 abandoned", nrx, 0);
        chk(modf, "R9 sticky", modf, 1);
        modf_clr = 1;
        @(negedge clk);
        modf_clr = 0;
        @(negedge clk);
        chk(!modf && !irq, "R9 cleared", {modf, irq}, 0);

        summary();
    end

endmodule